// File: doc/BRIEF.md
# Automatic Ethernet Flow-Control Trigger

This block sits beside the receive path of a host Ethernet MAC and decides when the link partner must be slowed down. It compares the receive FIFO fill level with a programmable threshold. It also watches per-frame indications from the receiver: start of a valid preamble, multicast, broadcast and destination-address match. When the level has been reached and an enabled frame condition occurs, it throttles the partner.

In half-duplex operation the block asserts a jam (backpressure) output for a programmable time. That time is counted in ticks of a 0.1 µs timebase, so the 10 Mb/s durations, which are 2.2 µs longer than the 100 Mb/s ones, come out exact. In full-duplex operation it raises a pause request toward the transmit side and holds it until that side acknowledges. The pause frame itself, collision handling and the FIFO sit outside this block.

Top module: `afc_flow_trigger`

## Requirements
- R1: After reset `bp_active` and `pause_req` are 0. With all four enable bits at 0 no frame indication and no FIFO level produces backpressure or a pause request.
- R2: A trigger fires only while `fifo_level >= fifo_thresh`. A level one below the threshold never triggers, and a level equal to the threshold does.
- R3: In half-duplex mode (`full_duplex`=0) with `cfg_en[0]`=0, a one-cycle pulse on `rx_mcast` with `cfg_en[3]`=1, on `rx_bcast` with `cfg_en[2]`=1, or on `rx_addr_hit` with `cfg_en[1]`=1 starts backpressure. A pulse whose class is not enabled does not.
- R4: In half-duplex mode with `cfg_en[0]`=1, backpressure starts on an `rx_preamble` pulse, and `cfg_en[3:1]` and the class indications are ignored.
- R5: In full-duplex mode `cfg_en[3:1]`, `rx_preamble` and the class indications have no effect. With `cfg_en[0]`=1, `pause_req` rises in the cycle after the FIFO level reaches the threshold. Backpressure never starts in full-duplex mode.
- R6: `pause_req` stays high until a cycle with `pause_ack`=1 and is low in the following cycle. It can rise again in the cycle after that if the condition still holds.
- R7: With `speed_100`=1, duration codes 0..7 on `cfg_dur` give backpressure lasting 50, 100, 150, 250, 500, 1000, 1500 and 2000 `tick` pulses.
- R8: With `speed_100`=0, every duration is 22 `tick` pulses longer than in R7.
- R9: Duration codes 8..15 give the same duration as code 7.
- R10: A trigger arriving while backpressure is active neither restarts nor extends it.
- R11: `bp_active` rises in the cycle after the trigger. A `tick` in the trigger cycle is not counted, and `bp_active` falls in the cycle after the N-th counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 4 | Trigger enables: [3] multicast, [2] broadcast, [1] address match, [0] any frame |
| cfg_dur | input | 4 | Backpressure duration code |
| full_duplex | input | 1 | 1 = full-duplex, 0 = half-duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tick | input | 1 | One-cycle pulse every 0.1 µs |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| fifo_thresh | input | LVL_W | Flow-control threshold |
| rx_preamble | input | 1 | Pulse: valid preamble of a new frame |
| rx_mcast | input | 1 | Pulse: frame is multicast |
| rx_bcast | input | 1 | Pulse: frame is broadcast |
| rx_addr_hit | input | 1 | Pulse: destination matches the host address |
| pause_ack | input | 1 | Transmit side has taken the pause request |
| bp_active | output | 1 | Jam/backpressure active |
| pause_req | output | 1 | Pause frame requested |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that `pause_ack` arrives only while a request is pending. They also assume that `full_duplex` is steady whenever a rise of either output is judged. The stimulus changes the duplex mode only while both outputs are idle, issues the tick every second cycle, and raises the acknowledge only against a pending request. Frame indications are one-cycle pulses, some of them sent while backpressure is already running, to exercise the no-retrigger rule.

// File: rtl/afc_pkg.sv
package afc_pkg;

   // Enable word layout: bit 3 multicast, bit 2 broadcast, bit 1 address hit, bit 0 any frame
   typedef struct packed {
      logic mcast;
      logic bcast;
      logic addr;
      logic any;
   } afc_en_t;

   // Base backpressure time in microseconds for the 100 Mb/s mode
   function automatic int unsigned afc_base_us(input logic [2:0] idx);
      int unsigned us;
      case (idx)
         3'd0:    us = 5;
         3'd1:    us = 10;
         3'd2:    us = 15;
         3'd3:    us = 25;
         3'd4:    us = 50;
         3'd5:    us = 100;
         3'd6:    us = 150;
         default: us = 200;
      endcase
      return us;
   endfunction

endpackage

// File: rtl/afc_dur_lut.sv
module afc_dur_lut #(
   parameter int unsigned TICKS_PER_US = 10,
   parameter int unsigned SLOW_EXTRA_TENTHS = 22,
   parameter int unsigned CNT_W = 12,
   parameter bit          CLAMP_HIGH = 1'b1
) (
   input  logic [3:0]       code_i,
   input  logic             fast_i,
   output logic [CNT_W-1:0] ticks_o
);
   import afc_pkg::*;

   localparam int unsigned SLOW_EXTRA = (SLOW_EXTRA_TENTHS * TICKS_PER_US) / 10;
   localparam int unsigned MAX_TICKS  = 200 * TICKS_PER_US + SLOW_EXTRA;

   initial begin
      assert (TICKS_PER_US % 10 == 0)
         else $error("afc_dur_lut: TICKS_PER_US must be a multiple of 10");
      assert (CNT_W >= $clog2(MAX_TICKS + 1))
         else $error("afc_dur_lut: CNT_W too narrow for longest duration");
   end

   logic [2:0]  idx;
   int unsigned total;

   generate
      if (CLAMP_HIGH) begin : g_clamp
         assign idx = code_i[3] ? 3'd7 : code_i[2:0];
      end else begin : g_wrap
         assign idx = code_i[2:0];
      end
   endgenerate

   always_comb begin
      total   = afc_base_us(idx) * TICKS_PER_US + (fast_i ? 0 : SLOW_EXTRA);
      ticks_o = CNT_W'(total);
   end

endmodule

// File: rtl/afc_trig.sv
module afc_trig #(
   parameter int unsigned LVL_W = 8,
   parameter bit          REG_CMP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  afc_pkg::afc_en_t en_i,
   input  logic             full_duplex_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] thresh_i,
   input  logic             preamble_i,
   input  logic             mcast_i,
   input  logic             bcast_i,
   input  logic             addr_i,
   output logic             hd_fire_o,
   output logic             fd_fire_o
);
   initial begin
      assert (LVL_W >= 1 && LVL_W <= 32)
         else $error("afc_trig: LVL_W out of range");
   end

   logic level_hit;
   logic class_hit;

   generate
      if (REG_CMP) begin : g_reg_cmp
         logic hit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= (level_i >= thresh_i);
         end
         assign level_hit = hit_q;
      end else begin : g_comb_cmp
         assign level_hit = (level_i >= thresh_i);
      end
   endgenerate

   always_comb begin
      class_hit = (en_i.mcast & mcast_i) | (en_i.bcast & bcast_i) | (en_i.addr & addr_i);
      hd_fire_o = ~full_duplex_i & level_hit & (en_i.any ? preamble_i : class_hit);
      fd_fire_o = full_duplex_i & en_i.any & level_hit;
   end

endmodule

// File: rtl/afc_bp_timer.sv
module afc_bp_timer #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             tick_i,
   output logic             active_o
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt == '0) begin
         if (fire_i) cnt <= load_i;
      end else if (tick_i) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign active_o = (cnt != '0);

   // R11: without a tick the interval cannot end
   a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      active_o && !tick_i |=> active_o);

   // R11: the interval ends only right after a counted tick
   a_r11_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> $past(tick_i));

   // R10: a running interval is never reloaded upward
   a_r10_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      active_o |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/afc_pause.sv
module afc_pause (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic ack_i,
   output logic req_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o <= 1'b0;
      end else if (req_o) begin
         if (ack_i) req_o <= 1'b0;
      end else if (fire_i) begin
         req_o <= 1'b1;
      end
   end

   // R6: request held until acknowledged
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && !ack_i |=> req_o);

   // R6: request drops the cycle after acknowledge
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && ack_i |=> !req_o);

endmodule

// File: rtl/afc_flow_trigger.sv
module afc_flow_trigger #(
   parameter int unsigned LVL_W = 8,
   parameter int unsigned TICKS_PER_US = 10,
   parameter int unsigned SLOW_EXTRA_TENTHS = 22,
   parameter int unsigned CNT_W = 12,
   parameter bit          CLAMP_HIGH = 1'b1,
   parameter bit          REG_CMP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cfg_en,
   input  logic [3:0]       cfg_dur,
   input  logic             full_duplex,
   input  logic             speed_100,
   input  logic             tick,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] fifo_thresh,
   input  logic             rx_preamble,
   input  logic             rx_mcast,
   input  logic             rx_bcast,
   input  logic             rx_addr_hit,
   input  logic             pause_ack,
   output logic             bp_active,
   output logic             pause_req
);
   import afc_pkg::*;

   afc_en_t          en;
   logic             hd_fire;
   logic             fd_fire;
   logic [CNT_W-1:0] dur_ticks;

   assign en = afc_en_t'(cfg_en);

   afc_trig #(.LVL_W(LVL_W), .REG_CMP(REG_CMP)) u_trig (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (en),
      .full_duplex_i (full_duplex),
      .level_i       (fifo_level),
      .thresh_i      (fifo_thresh),
      .preamble_i    (rx_preamble),
      .mcast_i       (rx_mcast),
      .bcast_i       (rx_bcast),
      .addr_i        (rx_addr_hit),
      .hd_fire_o     (hd_fire),
      .fd_fire_o     (fd_fire)
   );

   afc_dur_lut #(
      .TICKS_PER_US      (TICKS_PER_US),
      .SLOW_EXTRA_TENTHS (SLOW_EXTRA_TENTHS),
      .CNT_W             (CNT_W),
      .CLAMP_HIGH        (CLAMP_HIGH)
   ) u_lut (
      .code_i  (cfg_dur),
      .fast_i  (speed_100),
      .ticks_o (dur_ticks)
   );

   afc_bp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (hd_fire),
      .load_i   (dur_ticks),
      .tick_i   (tick),
      .active_o (bp_active)
   );

   afc_pause u_pause (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fd_fire),
      .ack_i  (pause_ack),
      .req_o  (pause_req)
   );

   // R5: pause requests only come from full-duplex with the any-frame enable
   a_r5_pause_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause_req) |-> $past(full_duplex && cfg_en[0]));

   // R5: backpressure never starts in full-duplex mode
   a_r5_no_fd_jam: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bp_active) |-> !$past(full_duplex));

   generate
      if (!REG_CMP) begin : g_lvl_chk
         // R2: every new interval or request needs the level reached
         a_r2_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(bp_active) || $rose(pause_req)) |-> $past(fifo_level >= fifo_thresh));
      end
   endgenerate

endmodule

// File: tb/tb_afc_flow_trigger.sv
`timescale 1ns/1ps
module tb_afc_flow_trigger;
   localparam int LVL_W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n = 1'b0;
   logic [3:0]       cfg_en = '0;
   logic [3:0]       cfg_dur = '0;
   logic             full_duplex = 1'b0;
   logic             speed_100 = 1'b1;
   logic             tick = 1'b0;
   logic [LVL_W-1:0] fifo_level = '0;
   logic [LVL_W-1:0] fifo_thresh = 8'd10;
   logic             rx_preamble = 1'b0;
   logic             rx_mcast = 1'b0;
   logic             rx_bcast = 1'b0;
   logic             rx_addr_hit = 1'b0;
   logic             pause_ack = 1'b0;
   logic             bp_active;
   logic             pause_req;

   afc_flow_trigger dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dur(cfg_dur),
      .full_duplex(full_duplex), .speed_100(speed_100), .tick(tick),
      .fifo_level(fifo_level), .fifo_thresh(fifo_thresh),
      .rx_preamble(rx_preamble), .rx_mcast(rx_mcast), .rx_bcast(rx_bcast),
      .rx_addr_hit(rx_addr_hit), .pause_ack(pause_ack),
      .bp_active(bp_active), .pause_req(pause_req)
   );

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   int    ref_cnt = 0;
   bit    ref_pause = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";

   function automatic int expect_ticks(int code, bit fast);
      int us_tab[8] = '{5, 10, 15, 25, 50, 100, 150, 200};
      int c = (code > 7) ? 7 : code;
      return us_tab[c] * 10 + (fast ? 0 : 22);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // one clock: update reference at the edge, compare away from it
   task automatic step();
      bit lvl, hd, fd, cls;
      tick = (cyc % 2 == 1);
      @(posedge clk);
      if (!rst_n) begin
         ref_cnt   = 0;
         ref_pause = 1'b0;
      end else begin
         lvl = (fifo_level >= fifo_thresh);
         cls = (cfg_en[3] && rx_mcast) || (cfg_en[2] && rx_bcast) || (cfg_en[1] && rx_addr_hit);
         hd  = !full_duplex && lvl && (cfg_en[0] ? rx_preamble : cls);
         fd  = full_duplex && cfg_en[0] && lvl;
         if (ref_cnt == 0) begin
            if (hd) ref_cnt = expect_ticks(cfg_dur, speed_100);
         end else if (tick) begin
            ref_cnt--;
         end
         if (ref_pause) begin
            if (pause_ack) ref_pause = 1'b0;
         end else if (fd) begin
            ref_pause = 1'b1;
         end
      end
      cyc++;
      @(negedge clk);
      chk(cur_req, bp_active, (ref_cnt != 0) ? 1 : 0);
      chk(cur_req, pause_req, ref_pause ? 1 : 0);
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // 0 preamble, 1 mcast, 2 bcast, 3 addr
   task automatic pulse(int which);
      case (which)
         0: rx_preamble = 1'b1;
         1: rx_mcast    = 1'b1;
         2: rx_bcast    = 1'b1;
         default: rx_addr_hit = 1'b1;
      endcase
      step();
      rx_preamble = 1'b0; rx_mcast = 1'b0; rx_bcast = 1'b0; rx_addr_hit = 1'b0;
   endtask

   task automatic drain();
      string keep = cur_req;
      cur_req = "R11";
      while (ref_cnt != 0) step();
      step();
      cur_req = keep;
   endtask

   initial begin
      @(negedge clk);
      steps(3);
      cur_req = "R1";
      chk("R1", bp_active, 0);
      chk("R1", pause_req, 0);
      rst_n = 1'b1;
      step();

      // R1: all enables cleared -> nothing
      fifo_level = 8'd50;
      for (int w = 0; w < 4; w++) pulse(w);
      full_duplex = 1'b1; steps(4); full_duplex = 1'b0;
      chk("R1", bp_active, 0);
      chk("R1", pause_req, 0);

      // R2: level gate
      cur_req = "R2";
      cfg_en = 4'b1000;
      fifo_level = 8'd9;
      pulse(1);
      chk("R2", bp_active, 0);
      fifo_level = 8'd10;
      pulse(1);
      chk("R2", bp_active, 1);
      drain();

      // R3: each class enable on its own, plus non-enabled class
      cur_req = "R3";
      cfg_dur = 4'd0;
      for (int b = 1; b < 4; b++) begin
         cfg_en = 4'(1 << (4 - b));
         pulse(b);
         chk("R3", bp_active, 1);
         drain();
      end
      cfg_en = 4'b0100;
      pulse(1); pulse(3); pulse(0);
      chk("R3", bp_active, 0);

      // R4: any-frame overrides class enables
      cur_req = "R4";
      cfg_en = 4'b1111;
      pulse(1); pulse(2); pulse(3);
      chk("R4", bp_active, 0);
      pulse(0);
      chk("R4", bp_active, 1);
      // R10: retrigger attempts while active
      cur_req = "R10";
      steps(20);
      pulse(0);
      steps(7);
      pulse(0);
      drain();
      chk("R10", bp_active, 0);

      // R11: trigger landing on a tick cycle and on a non-tick cycle
      cur_req = "R11";
      if (cyc % 2 == 0) step();
      pulse(0);
      drain();
      if (cyc % 2 == 1) step();
      pulse(0);
      drain();

      // R7 / R8: full duration table at both speeds
      for (int sp = 1; sp >= 0; sp--) begin
         speed_100 = sp[0];
         cur_req = sp ? "R7" : "R8";
         for (int c = 0; c < 8; c++) begin
            cfg_dur = 4'(c);
            pulse(0);
            chk(cur_req, bp_active, 1);
            drain();
         end
      end

      // R9: high codes clamp to the longest time
      cur_req = "R9";
      speed_100 = 1'b1; cfg_dur = 4'd8;  pulse(0); drain();
      speed_100 = 1'b0; cfg_dur = 4'd15; pulse(0); drain();
      cfg_dur = 4'd0;

      // R5: full-duplex
      cur_req = "R5";
      full_duplex = 1'b1;
      cfg_en = 4'b1110;
      for (int w = 0; w < 4; w++) pulse(w);
      chk("R5", pause_req, 0);
      chk("R5", bp_active, 0);
      cfg_en = 4'b0001;
      fifo_level = 8'd9;
      steps(3);
      chk("R5", pause_req, 0);
      fifo_level = 8'd10;
      step();
      chk("R5", pause_req, 1);
      pulse(0);
      chk("R5", bp_active, 0);

      // R6: hold, clear, re-raise
      cur_req = "R6";
      steps(6);
      chk("R6", pause_req, 1);
      pause_ack = 1'b1; step(); pause_ack = 1'b0;
      chk("R6", pause_req, 0);
      step();
      chk("R6", pause_req, 1);
      fifo_level = 8'd3;
      pause_ack = 1'b1; step(); pause_ack = 1'b0;
      steps(4);
      chk("R6", pause_req, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule